// File: doc/BRIEF.md
# Iterative Non-Restoring Divider with Q/M/T Flags

This block divides a two-word numerator by a one-word divisor, producing one quotient bit per clock. One combinational step handles each bit. The step takes the partial remainder, the divisor and three status flags: Q (the last quotient flag), M (the divisor sign) and T (the carry or quotient bit).

The step does not compare the remainder with the divisor. It decides between adding and subtracting from the stored Q and M. It then derives the new Q from three values: the remainder bit shifted out, the carry or borrow of that add or subtract, and M.

A setup operation loads the operands and initialises the flags, in either unsigned or signed form. A start pulse then runs exactly WIDTH steps. During the run, the low numerator word acts as a rotating register. Each cycle, its top bit feeds the step's fill input and the step's new T enters at its bottom. With an unsigned setup and a high word smaller than the divisor, the low word ends up holding the quotient. The remainder word is left uncorrected.

Top module: `nr_divider`

## Requirements
- R1: After reset, busy and done are 0, the Q, M and T flags are 0, and both data words read 0.
- R2: An unsigned setup (setup_valid=1, setup_signed=0) while idle has the following effects from the next cycle. rem_hi shows load_hi, quo_lo shows load_lo, the divisor is stored, and Q, M and T are all 0.
- R3: A signed setup while idle loads the operands as in R2. It also sets Q to bit WIDTH-1 of load_hi, sets M to bit WIDTH-1 of load_divisor, and sets T to Q XOR M.
- R4: Each step takes the top bit of the partial remainder as the provisional Q. It then shifts the remainder left by one. The fill bit enters the freed bit 0. In the sequencer, the fill bit is bit WIDTH-1 of the low word.
- R5: When the stored Q equals M, the step subtracts the divisor from the shifted remainder. Otherwise it adds the divisor. The arithmetic wraps modulo 2^WIDTH.
- R6: For a subtraction, the carry-out is 1 when the result is larger than the shifted value. For an addition, it is 1 when the result is smaller. The new Q is the provisional Q XOR the carry-out XOR M.
- R7: After every step, T is 1 exactly when the new Q equals M. The same T bit is shifted into bit 0 of the low word, whose top bit leaves.
- R8: A start pulse accepted while idle raises busy on the next cycle. busy then stays high for exactly WIDTH cycles, while one step is performed per cycle. done is high for the single cycle after the last step.
- R9: With an unsigned setup where load_hi < load_divisor, quo_lo holds floor((load_hi·2^WIDTH + load_lo) / load_divisor) when done is high.
- R10: start and setup_valid are ignored while busy. The run length, operands, flags and results are unaffected.
- R11: When setup_valid and start are both high in the same idle cycle, the setup takes effect and the start is dropped. busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Load operands and initialise the flags |
| setup_signed | input | 1 | 1 selects signed flag setup, 0 unsigned |
| load_hi | input | WIDTH | Initial partial remainder (numerator high word) |
| load_lo | input | WIDTH | Numerator low word |
| load_divisor | input | WIDTH | Divisor |
| start | input | 1 | Begin a WIDTH-step run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the last step |
| rem_hi | output | WIDTH | Current partial remainder |
| quo_lo | output | WIDTH | Low word / quotient register |
| q_flag | output | 1 | Q flag |
| m_flag | output | 1 | M flag |
| t_flag | output | 1 | T flag |

## Verification
Two pairs of requests can arrive in the same cycle. The first pair is a setup and a start. The bench raises both in one idle cycle. It then checks that busy stays low and that the flags and words show the freshly loaded setup values. The second pair is a start or setup arriving while a run is in progress. The bench injects both in the middle of a run. It then checks that done still comes exactly WIDTH cycles after the original start. It also checks that the final words and flags equal an independent bit-level model computed from the original operands.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
    typedef struct packed {
        logic q;
        logic m;
        logic t;
    } nrdiv_flags_t;
endpackage

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]      rem_in,
    input  logic [WIDTH-1:0]      dvsr,
    input  logic                  fill,
    input  nrdiv_pkg::nrdiv_flags_t flg_in,
    output logic [WIDTH-1:0]      rem_out,
    output nrdiv_pkg::nrdiv_flags_t flg_out
);
    logic [WIDTH-1:0] shifted;
    logic             q_prov;
    logic             do_sub;
    logic             cy;
    logic             q_new;

    always_comb begin
        q_prov  = rem_in[WIDTH-1];
        shifted = {rem_in[WIDTH-2:0], fill};
        do_sub  = (flg_in.q == flg_in.m);
        if (do_sub) begin
            rem_out = shifted - dvsr;
            cy      = (rem_out > shifted);
        end else begin
            rem_out = shifted + dvsr;
            cy      = (rem_out < shifted);
        end
        q_new     = q_prov ^ cy ^ flg_in.m;
        flg_out.q = q_new;
        flg_out.m = flg_in.m;
        flg_out.t = (q_new == flg_in.m);
    end
endmodule

// File: rtl/nrdiv_setup.sv
module nrdiv_setup #(
    parameter int WIDTH = 32
) (
    input  logic                    is_signed,
    input  logic [WIDTH-1:0]        numer_hi,
    input  logic [WIDTH-1:0]        dvsr,
    output nrdiv_pkg::nrdiv_flags_t flg_init
);
    always_comb begin
        if (is_signed) begin
            flg_init.q = numer_hi[WIDTH-1];
            flg_init.m = dvsr[WIDTH-1];
            flg_init.t = numer_hi[WIDTH-1] ^ dvsr[WIDTH-1];
        end else begin
            flg_init = '0;
        end
    end
endmodule

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 5
) (
    input  logic             busy_now,
    input  logic [CNT_W-1:0] cnt_now,
    input  logic             setup_req,
    input  logic             start_req,
    output logic             take_setup,
    output logic             take_start,
    output logic             last_step
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    always_comb begin
        take_setup = setup_req && !busy_now;
        take_start = start_req && !busy_now && !setup_req;
        last_step  = busy_now && (cnt_now == LAST);
    end
endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             setup_valid,
    input  logic             setup_signed,
    input  logic [WIDTH-1:0] load_hi,
    input  logic [WIDTH-1:0] load_lo,
    input  logic [WIDTH-1:0] load_divisor,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] rem_hi,
    output logic [WIDTH-1:0] quo_lo,
    output logic             q_flag,
    output logic             m_flag,
    output logic             t_flag
);
    import nrdiv_pkg::*;

    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    typedef struct packed {
        logic [WIDTH-1:0] rem;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] dv;
        nrdiv_flags_t     flg;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } state_t;

    state_t       st_d, st_q;
    nrdiv_flags_t init_flg, step_flg;
    logic [WIDTH-1:0] step_rem;
    logic         take_setup, take_start, last_step;

    nrdiv_setup #(.WIDTH(WIDTH)) u_setup (
        .is_signed (setup_signed),
        .numer_hi  (load_hi),
        .dvsr      (load_divisor),
        .flg_init  (init_flg)
    );

    nrdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem_in  (st_q.rem),
        .dvsr    (st_q.dv),
        .fill    (st_q.lo[WIDTH-1]),
        .flg_in  (st_q.flg),
        .rem_out (step_rem),
        .flg_out (step_flg)
    );

    nrdiv_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
        .busy_now   (st_q.busy),
        .cnt_now    (st_q.cnt),
        .setup_req  (setup_valid),
        .start_req  (start),
        .take_setup (take_setup),
        .take_start (take_start),
        .last_step  (last_step)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (take_setup) begin
            st_d.rem = load_hi;
            st_d.lo  = load_lo;
            st_d.dv  = load_divisor;
            st_d.flg = init_flg;
            st_d.cnt = '0;
        end else if (take_start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.rem = step_rem;
            st_d.lo  = {st_q.lo[WIDTH-2:0], step_flg.t};
            st_d.flg = step_flg;
            st_d.cnt = st_q.cnt + 1'b1;
            if (last_step) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign rem_hi = st_q.rem;
    assign quo_lo = st_q.lo;
    assign q_flag = st_q.flg.q;
    assign m_flag = st_q.flg.m;
    assign t_flag = st_q.flg.t;

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy) && !busy);
    assert_t_tracks_q_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (t_flag == (q_flag == m_flag)));
    assert_m_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(m_flag));
    assert_run_continues_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !last_step |=> busy && (st_q.cnt == $past(st_q.cnt) + 1'b1));
    assert_signed_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && setup_signed && !busy |=> t_flag == (q_flag ^ m_flag));
    assert_combo_start_dropped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        setup_valid && start && !busy |=> !busy);
endmodule

// File: tb/nr_divider_test.sv
module nr_divider_test;
    localparam int W = 32;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_valid = 1'b0, setup_signed = 1'b0, start = 1'b0;
    logic [W-1:0] load_hi = '0, load_lo = '0, load_divisor = '0;
    logic busy, done, q_flag, m_flag, t_flag;
    logic [W-1:0] rem_hi, quo_lo;

    int n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    nr_divider #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .setup_signed(setup_signed),
        .load_hi(load_hi), .load_lo(load_lo), .load_divisor(load_divisor), .start(start),
        .busy(busy), .done(done), .rem_hi(rem_hi), .quo_lo(quo_lo),
        .q_flag(q_flag), .m_flag(m_flag), .t_flag(t_flag)
    );

    // {hi, lo, divisor, expected unsigned quotient}
    localparam logic [4*W-1:0] VEC [NV] = '{
        {32'd0,          32'd100,        32'd7,          32'd14},
        {32'd0,          32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {32'd0,          32'hFFFFFFFF,   32'hFFFFFFFF,   32'd1},
        {32'd0,          32'd5,          32'd9,          32'd0},
        {32'd1,          32'd0,          32'd2,          32'h80000000},
        {32'd0,          32'h12345678,   32'h100,        32'h00123456},
        {32'd6,          32'd0,          32'd7,          32'hDB6DB6DB},
        {32'h7FFFFFFF,   32'hFFFFFFFF,   32'h80000000,   32'hFFFFFFFF}
    };

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // Independent model of a full run built from R4..R7
    task automatic model_run(input logic [W-1:0] hi, input logic [W-1:0] lo,
                             input logic [W-1:0] dv, input logic sgn,
                             output logic [W-1:0] r_o, output logic [W-1:0] l_o,
                             output logic [2:0] f_o);
        logic [W-1:0] r, l, sh, res;
        logic q, m, t, qp, cy;
        r = hi; l = lo;
        q = sgn ? hi[W-1] : 1'b0;
        m = sgn ? dv[W-1] : 1'b0;
        t = q ^ m;
        for (int i = 0; i < W; i++) begin
            qp = r[W-1];
            sh = {r[W-2:0], l[W-1]};
            if (q == m) begin res = sh - dv; cy = res > sh; end
            else        begin res = sh + dv; cy = res < sh; end
            q = qp ^ cy ^ m;
            t = (q == m);
            r = res;
            l = {l[W-2:0], t};
        end
        r_o = r; l_o = l; f_o = {q, m, t};
    endtask

    task automatic do_setup(logic sgn, logic [W-1:0] hi, logic [W-1:0] lo, logic [W-1:0] dv);
        setup_valid = 1'b1; setup_signed = sgn;
        load_hi = hi; load_lo = lo; load_divisor = dv;
        tick();
        setup_valid = 1'b0;
    endtask

    // start, then wait for done; returns cycles busy was high
    task automatic do_run(output int busy_cycles, input bit poke);
        start = 1'b1;
        tick();
        start = 1'b0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            if (poke && busy_cycles == 5) begin
                start = 1'b1; setup_valid = 1'b1; setup_signed = 1'b1;
                load_hi = 32'hDEADBEEF; load_lo = 32'h0; load_divisor = 32'h3;
            end else begin
                start = 1'b0; setup_valid = 1'b0;
            end
            tick();
            if (busy_cycles > 100) break;
        end
        start = 1'b0; setup_valid = 1'b0;
    endtask

    initial begin
        #3_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [W-1:0] er, el;
        logic [2:0] ef;
        int bc;
        tick(); tick();
        // R1 reset state
        check("R1 busy", W'(busy), 0);
        check("R1 done", W'(done), 0);
        check("R1 flags", W'({q_flag, m_flag, t_flag}), 0);
        check("R1 rem", rem_hi, 0);
        check("R1 lo", quo_lo, 0);
        rst_n = 1'b1;
        tick();

        foreach (VEC[k]) begin
            logic [W-1:0] vh, vl, vd, vq;
            {vh, vl, vd, vq} = VEC[k];
            do_setup(1'b0, vh, vl, vd);
            check("R2 rem load", rem_hi, vh);
            check("R2 lo load", quo_lo, vl);
            check("R2 flags clear", W'({q_flag, m_flag, t_flag}), 0);
            do_run(bc, 1'b0);
            check("R8 busy length", W'(bc), W);
            check("R8 done pulse", W'(done), 1);
            check("R9 quotient", quo_lo, vq);
            model_run(vh, vl, vd, 1'b0, er, el, ef);
            check("R4 R5 remainder word", rem_hi, er);
            check("R6 R7 flags", W'({q_flag, m_flag, t_flag}), W'(ef));
            tick();
            check("R8 done drops", W'(done), 0);
        end

        // R3 signed setup, both sign combinations
        do_setup(1'b1, 32'h80000010, 32'h1234, 32'h00000005);
        check("R3 signed flags neg/pos", W'({q_flag, m_flag, t_flag}), W'(3'b101));
        do_run(bc, 1'b0);
        model_run(32'h80000010, 32'h1234, 32'h5, 1'b1, er, el, ef);
        check("R5 R6 signed remainder", rem_hi, er);
        check("R7 signed low word", quo_lo, el);
        check("R7 signed flags", W'({q_flag, m_flag, t_flag}), W'(ef));
        tick();
        do_setup(1'b1, 32'h7FFF0000, 32'hFFFF0001, 32'hFFFFFFF9);
        check("R3 signed flags pos/neg", W'({q_flag, m_flag, t_flag}), W'(3'b011));
        do_run(bc, 1'b0);
        model_run(32'h7FFF0000, 32'hFFFF0001, 32'hFFFFFFF9, 1'b1, er, el, ef);
        check("R5 add path remainder", rem_hi, er);
        check("R7 add path low word", quo_lo, el);
        tick();
        do_setup(1'b1, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFE);
        check("R3 signed flags neg/neg", W'({q_flag, m_flag, t_flag}), W'(3'b110));

        // R10 start and setup while busy are ignored
        do_setup(1'b0, 32'd0, 32'd1000, 32'd33);
        do_run(bc, 1'b1);
        check("R10 run length", W'(bc), W);
        check("R10 quotient", quo_lo, 32'd30);
        model_run(32'd0, 32'd1000, 32'd33, 1'b0, er, el, ef);
        check("R10 remainder word", rem_hi, er);
        check("R10 flags", W'({q_flag, m_flag, t_flag}), W'(ef));
        tick();
        check("R10 no restart", W'(busy), 0);

        // R11 setup and start together
        setup_valid = 1'b1; start = 1'b1; setup_signed = 1'b1;
        load_hi = 32'h80000000; load_lo = 32'h55; load_divisor = 32'h80000000;
        tick();
        setup_valid = 1'b0; start = 1'b0;
        check("R11 busy stays low", W'(busy), 0);
        check("R11 setup applied rem", rem_hi, 32'h80000000);
        check("R11 setup applied flags", W'({q_flag, m_flag, t_flag}), W'(3'b110));
        tick();
        check("R11 still idle", W'(busy), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule